// File: doc/BRIEF.md
# Clock Synthesizer Divider Search Engine

This block works out the three divider settings of a clock synthesizer whose oscillator runs at 8 × ref × m / n and whose output is that oscillator divided by 2^p. A controller presents the reference frequency, the wanted output frequency and a lower and upper limit, all as unsigned integers in units of 100 Hz, and pulses `start`. The engine then runs a fixed sequence without further input: it clamps the request, picks the post-divider exponent, divides to get a fixed-point step, sweeps the feedback divisor and finally divides again to report the frequency that the chosen settings produce.

All arithmetic is integer. The per-step increment of m and the running candidate are unsigned fixed-point values with `FRAC` fractional bits. Both divisions share one restoring divider that yields one quotient bit per cycle. The result is held on the outputs until the next run completes, and `done` marks the cycle in which it becomes valid.

Top module: `clk_div_search`

## Requirements
- R1: The requested frequency is first limited to the range: below `min_freq` it becomes `min_freq`, then above `max_freq` it becomes `max_freq`.
- R2: The limited value is doubled while it is below `VCO_MIN` (1,100,000, i.e. 110 MHz) and fewer than 3 doublings were done; the number of doublings is the exponent p (0 to 3), reported on `p_code`.
- R3: The increment is floor(vco × 2^FRAC / (8 × ref)); the candidate m for n = 3 is three increments, and each further n up to 25 adds one increment.
- R4: A candidate m below 3.0 or above 64.0 (64.0 itself allowed) is never selected.
- R5: Among the remaining candidates the one with the smallest fractional part wins; an equal fraction at a later n does not replace the earlier one.
- R6: `m_code` = 65 − m (integer part of the winner), `n_code` = 65 − n, each 8 bits.
- R7: `out_freq` = floor(8 × ref × m / n) shifted right by p.
- R8: When no candidate survives R4, `err` is 1 with `done`, and `m_code`, `n_code`, `p_code` and `out_freq` are all 0.
- R9: `busy` is high from the cycle after an accepted `start` until the result is out; `done` is a single-cycle pulse with `busy` low; a `start` while busy is ignored; the outputs change only in a `done` cycle.
- R10: After reset `busy`, `done`, `err` and all codes and `out_freq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when the engine is idle |
| ref_freq | input | FW | Reference frequency, 100 Hz units |
| req_freq | input | FW | Requested output frequency, 100 Hz units |
| min_freq | input | FW | Lower limit for the request |
| max_freq | input | FW | Upper limit for the request |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse, result valid |
| err | output | 1 | No usable m found |
| m_code | output | 8 | 65 minus selected m |
| n_code | output | 8 | 65 minus selected n |
| p_code | output | 2 | Post-divider exponent |
| out_freq | output | FW | Achieved frequency, 100 Hz units |

## Verification
The assertions take for granted that `ref_freq` is nonzero, that `min_freq` does not exceed `max_freq`, and that the inputs present at the accepted `start` are the ones the run uses, since they are captured then. The stimulus only issues nonzero references and ordered limits, drives every input at the falling edge, and deliberately raises `start` with different operands during a run to show that such a request leaves the run and its result untouched. Vectors are chosen to hit each exponent value, both clamp directions, an exact-integer tie, a single candidate just under the upper m limit and a case with no candidate at all.

// File: rtl/clk_div_search_pkg.sv
package clk_div_search_pkg;
  localparam int N_FIRST   = 3;
  localparam int N_LAST    = 25;
  localparam int M_MIN     = 3;
  localparam int M_MAX     = 64;
  localparam int CODE_BASE = 65;
  localparam int P_LIMIT   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KICK_INC,
    ST_WAIT_INC,
    ST_SWEEP_GO,
    ST_SWEEP_WAIT,
    ST_KICK_OUT,
    ST_WAIT_OUT
  } srch_state_e;
endpackage

// File: rtl/clk_div_prescale.sv
module clk_div_prescale #(
  parameter int FW      = 32,
  parameter int VCO_MIN = 1_100_000
) (
  input  logic [FW-1:0]   req_freq,
  input  logic [FW-1:0]   min_freq,
  input  logic [FW-1:0]   max_freq,
  output logic [FW+2:0]   vco_val,
  output logic [1:0]      p_exp
);
  import clk_div_search_pkg::*;
  localparam int VW = FW + 3;
  localparam logic [VW-1:0] VMIN = VW'(VCO_MIN);

  function automatic logic [FW-1:0] limit_req(input logic [FW-1:0] r,
                                              input logic [FW-1:0] lo,
                                              input logic [FW-1:0] hi);
    logic [FW-1:0] t;
    t = r;
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    return t;
  endfunction

  always_comb begin
    logic [VW-1:0] v;
    logic [1:0]    p;
    v = {3'b000, limit_req(req_freq, min_freq, max_freq)};
    p = 2'd0;
    for (int i = 0; i < P_LIMIT; i++) begin
      if (v < VMIN) begin
        v = v << 1;
        p = p + 2'd1;
      end
    end
    vco_val = v;
    p_exp   = p;
  end
endmodule

// File: rtl/clk_div_divider.sv
module clk_div_divider #(
  parameter int DW = 51,
  parameter int VW = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quot
);
  localparam int CNTW = $clog2(DW + 1);

  logic [VW-1:0]   rem;
  logic [DW-1:0]   qsh;
  logic [CNTW-1:0] cnt;
  logic [VW:0]     trial;
  logic [VW:0]     next_rem;
  logic            qbit;

  always_comb begin
    trial = {rem, qsh[DW-1]};
    if (trial >= {1'b0, divisor}) begin
      next_rem = trial - {1'b0, divisor};
      qbit     = 1'b1;
    end else begin
      next_rem = trial;
      qbit     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      qsh  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        rem  <= '0;
        qsh  <= dividend;
        cnt  <= CNTW'(DW);
        busy <= 1'b1;
      end else if (busy) begin
        rem <= next_rem[VW-1:0];
        qsh <= {qsh[DW-2:0], qbit};
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = qsh;

  assert_div_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  assert_div_rem_below_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && divisor != '0) |-> ({1'b0, rem} < {1'b0, divisor}));
endmodule

// File: rtl/clk_div_sweep.sv
module clk_div_sweep #(
  parameter int IW   = 51,
  parameter int FRAC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [IW-1:0] inc,
  output logic          done,
  output logic          found,
  output logic [6:0]    best_m,
  output logic [4:0]    best_n
);
  import clk_div_search_pkg::*;
  localparam int CW = IW + 5;
  localparam logic [CW-1:0] LO_LIM = CW'(M_MIN) << FRAC;
  localparam logic [CW-1:0] HI_LIM = CW'(M_MAX) << FRAC;

  logic [CW-1:0]   cand;
  logic [4:0]      n_cur;
  logic            running;
  logic [FRAC-1:0] best_frac;
  logic [FRAC-1:0] cand_frac;
  logic            cand_valid;
  logic            cand_better;

  assign cand_frac   = cand[FRAC-1:0];
  assign cand_valid  = running && (cand >= LO_LIM) && (cand <= HI_LIM);
  assign cand_better = cand_valid && (!found || (cand_frac < best_frac));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand      <= '0;
      n_cur     <= '0;
      running   <= 1'b0;
      done      <= 1'b0;
      found     <= 1'b0;
      best_frac <= '0;
      best_m    <= '0;
      best_n    <= '0;
    end else begin
      done <= 1'b0;
      if (go && !running) begin
        cand    <= CW'(inc) + CW'(inc) + CW'(inc);
        n_cur   <= 5'(N_FIRST);
        running <= 1'b1;
        found   <= 1'b0;
      end else if (running) begin
        if (cand_better) begin
          best_frac <= cand_frac;
          best_m    <= cand[FRAC+6:FRAC];
          best_n    <= n_cur;
          found     <= 1'b1;
        end
        cand  <= cand + CW'(inc);
        n_cur <= n_cur + 5'd1;
        if (n_cur == 5'(N_LAST)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assert_best_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (best_m >= 7'(M_MIN) && best_m <= 7'(M_MAX)));
  assert_tie_keeps_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && found && cand_frac == best_frac) |=> (best_n == $past(best_n)));
  assert_n_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (n_cur >= 5'(N_FIRST) && n_cur <= 5'(N_LAST)));
endmodule

// File: rtl/clk_div_search.sv
module clk_div_search #(
  parameter int FW      = 32,
  parameter int FRAC    = 16,
  parameter int VCO_MIN = 1_100_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] ref_freq,
  input  logic [FW-1:0] req_freq,
  input  logic [FW-1:0] min_freq,
  input  logic [FW-1:0] max_freq,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [7:0]    m_code,
  output logic [7:0]    n_code,
  output logic [1:0]    p_code,
  output logic [FW-1:0] out_freq
);
  import clk_div_search_pkg::*;
  localparam int VW = FW + 3;
  localparam int DW = VW + FRAC;
  localparam logic [VW-1:0] VMIN = VW'(VCO_MIN);

  srch_state_e   state;
  logic [VW-1:0] vco_pre;
  logic [1:0]    p_pre;
  logic [VW-1:0] vco_r;
  logic [1:0]    p_r;
  logic [FW-1:0] ref_r;
  logic [DW-1:0] inc_r;

  logic          div_go, div_busy, div_done;
  logic [DW-1:0] div_dividend, div_quot;
  logic [VW-1:0] div_divisor;
  logic          sw_go, sw_done, sw_found;
  logic [6:0]    sw_m;
  logic [4:0]    sw_n;
  logic          accept_start;

  clk_div_prescale #(.FW(FW), .VCO_MIN(VCO_MIN)) u_pre (
    .req_freq(req_freq), .min_freq(min_freq), .max_freq(max_freq),
    .vco_val(vco_pre), .p_exp(p_pre)
  );

  function automatic logic [DW-1:0] step_dividend(input logic [VW-1:0] v);
    return DW'(v) << FRAC;
  endfunction

  function automatic logic [DW-1:0] freq_dividend(input logic [FW-1:0] r,
                                                  input logic [6:0]    m);
    return DW'({r, 3'b000}) * DW'(m);
  endfunction

  assign accept_start = (state == ST_IDLE) && start;
  assign div_go = (state == ST_KICK_INC) || (state == ST_KICK_OUT);
  assign sw_go  = (state == ST_SWEEP_GO);
  assign div_dividend = (state == ST_KICK_OUT) ? freq_dividend(ref_r, sw_m)
                                               : step_dividend(vco_r);
  assign div_divisor  = (state == ST_KICK_OUT || state == ST_WAIT_OUT)
                        ? VW'(sw_n) : VW'({ref_r, 3'b000});

  clk_div_divider #(.DW(DW), .VW(VW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_dividend),
    .divisor(div_divisor), .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  clk_div_sweep #(.IW(DW), .FRAC(FRAC)) u_sweep (
    .clk(clk), .rst_n(rst_n), .go(sw_go), .inc(inc_r), .done(sw_done),
    .found(sw_found), .best_m(sw_m), .best_n(sw_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      vco_r    <= '0;
      p_r      <= '0;
      ref_r    <= '0;
      inc_r    <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      m_code   <= '0;
      n_code   <= '0;
      p_code   <= '0;
      out_freq <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept_start) begin
          vco_r <= vco_pre;
          p_r   <= p_pre;
          ref_r <= ref_freq;
          state <= ST_KICK_INC;
        end
        ST_KICK_INC: state <= ST_WAIT_INC;
        ST_WAIT_INC: if (div_done) begin
          inc_r <= div_quot;
          state <= ST_SWEEP_GO;
        end
        ST_SWEEP_GO: state <= ST_SWEEP_WAIT;
        ST_SWEEP_WAIT: if (sw_done) begin
          if (sw_found) begin
            state <= ST_KICK_OUT;
          end else begin
            err      <= 1'b1;
            m_code   <= '0;
            n_code   <= '0;
            p_code   <= '0;
            out_freq <= '0;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_KICK_OUT: state <= ST_WAIT_OUT;
        ST_WAIT_OUT: if (div_done) begin
          err      <= 1'b0;
          m_code   <= 8'(CODE_BASE) - {1'b0, sw_m};
          n_code   <= 8'(CODE_BASE) - {3'b000, sw_n};
          p_code   <= p_r;
          out_freq <= FW'(div_quot >> p_r);
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_codes_only_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_code != $past(m_code) || out_freq != $past(out_freq)) |-> done);
  assert_err_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (m_code == 8'd0 && n_code == 8'd0 && p_code == 2'd0 && out_freq == '0));
  assert_code_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (m_code >= 8'd1 && m_code <= 8'd62 && n_code >= 8'd40 && n_code <= 8'd62));
  assert_vco_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p_pre != 2'(P_LIMIT)) |-> (vco_pre >= VMIN));
  assert_vco_last_double_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (p_pre != 2'd0) |-> ((vco_pre >> 1) < VMIN));
endmodule

// File: tb/clk_div_search_test.sv
module clk_div_search_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 32;

  typedef struct {
    logic [7:0]    m;
    logic [7:0]    n;
    logic [1:0]    p;
    logic [FW-1:0] f;
    logic          e;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] ref_freq = '0, req_freq = '0, min_freq = '0, max_freq = '0;
  logic busy, done, err;
  logic [7:0] m_code, n_code;
  logic [1:0] p_code;
  logic [FW-1:0] out_freq;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  exp_t sb[$];
  exp_t last_exp;
  logic prev_done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_div_search #(.FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_freq(ref_freq),
    .req_freq(req_freq), .min_freq(min_freq), .max_freq(max_freq),
    .busy(busy), .done(done), .err(err), .m_code(m_code), .n_code(n_code),
    .p_code(p_code), .out_freq(out_freq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input longint rf, input longint rq,
                                 input longint lo, input longint hi, input string tag);
    exp_t x;
    longint t, v, inc, c, bf, bm, bn;
    int p;
    bit hit;
    t = rq;
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    v = t;
    p = 0;
    while (p < 3 && v < 1100000) begin
      v = v * 2;
      p++;
    end
    inc = (v * 65536) / (rf * 8);
    c = inc * 3;
    hit = 0; bf = 0; bm = 0; bn = 0;
    for (int n = 3; n <= 25; n++) begin
      if (c >= 3 * 65536 && c <= 64 * 65536) begin
        if (!hit || (c % 65536) < bf) begin
          hit = 1; bf = c % 65536; bm = c / 65536; bn = n;
        end
      end
      c = c + inc;
    end
    x.tag = tag;
    if (!hit) begin
      x.e = 1'b1; x.m = 8'd0; x.n = 8'd0; x.p = 2'd0; x.f = '0;
    end else begin
      x.e = 1'b0;
      x.m = 8'(65 - bm);
      x.n = 8'(65 - bn);
      x.p = 2'(p);
      x.f = FW'(((rf * 8 * bm) / bn) >> p);
    end
    return x;
  endfunction

  task automatic launch(input longint rf, input longint rq, input longint lo,
                        input longint hi, input string tag);
    while (busy) @(negedge clk);
    ref_freq = FW'(rf); req_freq = FW'(rq); min_freq = FW'(lo); max_freq = FW'(hi);
    start = 1'b1;
    sb.push_back(model(rf, rq, lo, hi, tag));
    pushed++;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", longint'(busy), 1);
  endtask

  // Monitor: compares each result against the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(prev_done == 1'b0, "R9 done single pulse", longint'(prev_done), 0);
        check(busy == 1'b0, "R9 done with busy low", longint'(busy), 0);
        if (sb.size() == 0) begin
          check(1'b0, "R9 unexpected result", 1, 0);
        end else begin
          exp_t x;
          x = sb.pop_front();
          popped++;
          last_exp = x;
          check(err == x.e, {"R8 err ", x.tag}, longint'(err), longint'(x.e));
          check(m_code == x.m, {"R3 R4 R5 R6 m_code ", x.tag}, longint'(m_code), longint'(x.m));
          check(n_code == x.n, {"R3 R5 R6 n_code ", x.tag}, longint'(n_code), longint'(x.n));
          check(p_code == x.p, {"R1 R2 p_code ", x.tag}, longint'(p_code), longint'(x.p));
          check(out_freq == x.f, {"R7 out_freq ", x.tag}, longint'(out_freq), longint'(x.f));
        end
      end
      prev_done <= done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R10 control idle",
          longint'({busy, done, err}), 0);
    check(m_code == 8'd0 && n_code == 8'd0 && p_code == 2'd0 && out_freq == '0,
          "R10 outputs zero", longint'(m_code) + longint'(n_code) + longint'(out_freq), 0);

    launch(143180, 250000, 100000, 2200000, "p3 typical");         // R2
    launch(143180, 1350000, 100000, 2200000, "p0 high");           // R2
    launch(143180, 600000, 100000, 2200000, "p1 mid");             // R2
    launch(143180, 50000, 100000, 2200000, "clamp low cap p");     // R1 R2
    launch(143180, 3000000, 100000, 2200000, "clamp high");        // R1
    launch(200000, 1600000, 100000, 2200000, "integer tie");       // R5
    launch(300000, 900000, 100000, 2200000, "late first hit");     // R3 R5
    launch(10000, 1500000, 100000, 2200000, "m upper window");     // R4
    launch(5000000, 1200000, 100000, 2200000, "no candidate");     // R8
    launch(250000, 1100000, 100000, 2200000, "at vco floor");      // R2

    // R9: start during a run is ignored
    launch(143180, 700000, 100000, 2200000, "busy guard");
    repeat (10) @(negedge clk);
    ref_freq = 32'd5000000; req_freq = 32'd1200000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (200) @(negedge clk);
    check(popped == pushed, "R9 one result per accepted start", longint'(popped), longint'(pushed));
    // R9 outputs held after the last result
    check(m_code == last_exp.m && out_freq == last_exp.f && err == last_exp.e,
          "R9 outputs held", longint'(out_freq), longint'(last_exp.f));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule